// File: doc/BRIEF.md
# PWM Period-Counted Fault Shutdown Handler

This block watches four fault lines for one PWM channel: current limit, a combined fault that covers both outputs, and one fault for each of the two outputs. It turns the channel's A and B outputs off once a fault has persisted long enough. Each line has its own counter, and that counter counts PWM periods that contain at least one fault event. A period-end strobe from the timing logic closes each period. A period that ends clean sets that line's count back to zero. When the count reaches the programmed limit, the block latches a shutdown mask for the outputs that the fault guards. A limit of zero trips on the first event and does not wait for the period to end.

The masks stay set until the channel is restarted. A restart means that either the local channel enable or the global enable goes low and comes back. A small register port holds the enables, the per-fault limits and the interrupt enables. It also holds two flag registers that clear when read: the trip status and the interrupt flags. Any interrupt flag that is set drives the interrupt request.

Top module: `pwm_fault_shutdown`

## Requirements
- R1: After reset, `shut_a_o`, `shut_b_o` and `irq_o` are 0, and every register reads 0.
- R2: Fault bit 2 masks output A only. Fault bit 3 masks output B only. Fault bits 0 (current limit) and 1 (combined) mask both outputs.
- R3: With a limit of 0, an enabled fault sets its mask 3 clock cycles after the fault input rises: two synchronizer stages plus the latch. No period-end strobe is needed.
- R4: With a limit N > 0, the mask sets at the period-end strobe that closes the Nth consecutive faulted period. A limit of 31 needs 31 such periods.
- R5: A counter advances at most once per period, however many separate fault pulses fall inside that period.
- R6: A period that ends with no event on a fault line resets that line's counter to 0.
- R7: A mask stays set while `chan_en_i` and `glb_en_i` are both high. Driving either one low for a cycle clears all counters, masks and per-period flags.
- R8: The control register (address 0) has two enable bits. Bit 0 enables the current-limit fault. Bit 1 enables faults 1 to 3. A disabled fault never counts and never trips.
- R9: The status register (address 2) sets bit i when fault i trips and clears when read. A trip in the same cycle as the read leaves the bit set.
- R10: The interrupt register (address 3) sets bit i when fault i trips and control bit 4+i is set. It clears when read. `irq_o` is high while any bit of this register is set.
- R11: The limit register (address 1) holds fault i's limit in bits [8i+4:8i]. Registers 0 and 1 read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Local channel enable |
| glb_en_i | input | 1 | Global enable |
| period_end_i | input | 1 | One-cycle strobe that closes a PWM period |
| fault_i | input | 4 | Asynchronous fault lines: 0 current limit, 1 combined, 2 A, 3 B |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears the flag registers) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| shut_a_o | output | 1 | Shutdown mask for output A |
| shut_b_o | output | 1 | Shutdown mask for output B |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 5-bit counter width and a 32-bit data bus. That width makes the largest limit, 31 periods, cheap enough to run in full. The bench therefore checks the top limit by stepping 30 faulted periods with the mask still clear, then one more period that sets it. The small limits of 0 to 3 used elsewhere let one vector table walk through trips, clean-period resets and restarts on every fault line.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int N_FLT        = 4;
  localparam int FLT_CL       = 0;
  localparam int FLT_AB       = 1;
  localparam int FLT_A        = 2;
  localparam int FLT_B        = 3;
  localparam int FIELD_STRIDE = 8;

  localparam int CTRL_CL_EN   = 0;
  localparam int CTRL_GRP_EN  = 1;
  localparam int CTRL_IE_LSB  = 4;

  // which trips mask each output
  localparam logic [N_FLT-1:0] MASK_A = (N_FLT'(1) << FLT_CL) | (N_FLT'(1) << FLT_AB) | (N_FLT'(1) << FLT_A);
  localparam logic [N_FLT-1:0] MASK_B = (N_FLT'(1) << FLT_CL) | (N_FLT'(1) << FLT_AB) | (N_FLT'(1) << FLT_B);

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_MAX  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_INT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fsd_sync.sv
module fsd_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fsd_fault_cnt.sv
module fsd_fault_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             evt_i,
  input  logic             period_end_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             trip_o,
  output logic             trip_set_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   cnt_inc;
  logic             seen_q, seen_n;
  logic             trip_q, trip_n;
  logic             faulted;

  always_comb begin
    faulted = seen_q | evt_i;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    cnt_n   = cnt_q;
    seen_n  = faulted;
    trip_n  = trip_q;
    if (!run_i) begin
      cnt_n  = '0;
      seen_n = 1'b0;
      trip_n = 1'b0;
    end else if (trip_q) begin
      seen_n = 1'b0;
    end else if (evt_i && (max_i == '0)) begin
      trip_n = 1'b1;
      seen_n = 1'b0;
    end else if (period_end_i) begin
      seen_n = 1'b0;
      if (faulted) begin
        cnt_n = cnt_inc[CNT_W-1:0];
        if (cnt_inc >= {1'b0, max_i}) trip_n = 1'b1;
      end else begin
        cnt_n = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      trip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      trip_q <= trip_n;
    end
  end

  assign trip_o     = trip_q;
  assign trip_set_o = trip_n & ~trip_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $past(trip_q)) |-> trip_q); // R7
  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (cnt_q == '0 && !trip_q && !seen_q)); // R7
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q) && cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1 && $past(period_end_i))); // R5
endmodule

// File: rtl/fsd_regs.sv
module fsd_regs
  import fsd_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DW    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [1:0]             addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic [N_FLT-1:0]       trip_set_i,
  output logic                   cl_en_o,
  output logic                   grp_en_o,
  output logic [N_FLT*CNT_W-1:0] max_o,
  output logic                   irq_o
);
  logic                   cl_en_q, grp_en_q;
  logic [N_FLT-1:0]       ie_q, stat_q, int_q;
  logic [N_FLT*CNT_W-1:0] max_q;
  logic                   rd_stat, rd_int;
  logic                   unused_wdata;

  assign rd_stat      = rd_i && (addr_i == ADDR_STAT);
  assign rd_int       = rd_i && (addr_i == ADDR_INT);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_en_q  <= 1'b0;
      grp_en_q <= 1'b0;
      ie_q     <= '0;
      max_q    <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) begin
        cl_en_q  <= wdata_i[CTRL_CL_EN];
        grp_en_q <= wdata_i[CTRL_GRP_EN];
        ie_q     <= wdata_i[CTRL_IE_LSB +: N_FLT];
      end
      if (addr_i == ADDR_MAX) begin
        for (int i = 0; i < N_FLT; i++)
          max_q[i*CNT_W +: CNT_W] <= wdata_i[i*FIELD_STRIDE +: CNT_W];
      end
    end
  end

  // set wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      int_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~{N_FLT{rd_stat}}) | trip_set_i;
      int_q  <= (int_q & ~{N_FLT{rd_int}}) | (trip_set_i & ie_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_CL_EN]            = cl_en_q;
        rdata_o[CTRL_GRP_EN]           = grp_en_q;
        rdata_o[CTRL_IE_LSB +: N_FLT]  = ie_q;
      end
      ADDR_MAX: begin
        for (int i = 0; i < N_FLT; i++)
          rdata_o[i*FIELD_STRIDE +: CNT_W] = max_q[i*CNT_W +: CNT_W];
      end
      ADDR_STAT: rdata_o[N_FLT-1:0] = stat_q;
      default:   rdata_o[N_FLT-1:0] = int_q;
    endcase
  end

  assign cl_en_o  = cl_en_q;
  assign grp_en_o = grp_en_q;
  assign max_o    = max_q;
  assign irq_o    = |int_q;

  AST_STAT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q)) != '0) |-> ($past(trip_set_i) != '0)); // R9
  AST_STAT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_stat) && $past(trip_set_i) == '0) |-> (stat_q == '0)); // R9
  AST_INT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_q & ~$past(int_q) & ~$past(trip_set_i & ie_q)) == '0)); // R10
endmodule

// File: rtl/pwm_fault_shutdown.sv
module pwm_fault_shutdown
  import fsd_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chan_en_i,
  input  logic              glb_en_i,
  input  logic              period_end_i,
  input  logic [N_FLT-1:0]  fault_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              shut_a_o,
  output logic              shut_b_o,
  output logic              irq_o
);
  logic                   run;
  logic                   cl_en, grp_en;
  logic [N_FLT-1:0]       flt_sync, flt_en, evt, trip, trip_set;
  logic [N_FLT*CNT_W-1:0] max_flat;

  assign run = chan_en_i & glb_en_i;

  fsd_sync #(.W(N_FLT)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fault_i),
    .q_o   (flt_sync)
  );

  fsd_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .trip_set_i(trip_set),
    .cl_en_o   (cl_en),
    .grp_en_o  (grp_en),
    .max_o     (max_flat),
    .irq_o     (irq_o)
  );

  for (genvar g = 0; g < N_FLT; g++) begin : g_flt
    if (g == FLT_CL) begin : g_cl
      assign flt_en[g] = cl_en;
    end else begin : g_grp
      assign flt_en[g] = grp_en;
    end
    assign evt[g] = flt_sync[g] & flt_en[g] & run;

    fsd_fault_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .evt_i       (evt[g]),
      .period_end_i(period_end_i),
      .max_i       (max_flat[g*CNT_W +: CNT_W]),
      .trip_o      (trip[g]),
      .trip_set_o  (trip_set[g])
    );
  end

  assign shut_a_o = |(trip & MASK_A);
  assign shut_b_o = |(trip & MASK_B);

  AST_SHUT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_a_o || shut_b_o) |-> $past(run)); // R7
endmodule

// File: tb/pwm_fault_shutdown_tb.sv
`timescale 1ns/1ps
module pwm_fault_shutdown_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b1, glb_en = 1'b1, pend = 1'b0;
  logic [3:0]  fault = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        shut_a, shut_b, irq;
  int          n_cmp = 0, n_mis = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  pwm_fault_shutdown dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .glb_en_i(glb_en),
    .period_end_i(pend), .fault_i(fault), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .shut_a_o(shut_a), .shut_b_o(shut_b), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic restart();
    chan_en = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    @(negedge clk);
  endtask

  // n pulses of pattern f, each drained through the synchronizer, then one strobe
  task automatic period(input logic [3:0] f, input int n);
    for (int p = 0; p < n; p++) begin
      fault = f;
      repeat (2) @(negedge clk);
      fault = '0;
      repeat (3) @(negedge clk);
    end
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  // {restart, fault[3:0], exp_a, exp_b}; limits CL=3 AB=2 A=1 B=2
  localparam logic [6:0] VEC [15] = '{
    7'b1_0000_00, 7'b0_0100_10, 7'b0_0000_10, 7'b1_1000_00, 7'b0_0000_00,
    7'b0_1000_00, 7'b0_1000_01, 7'b1_0010_00, 7'b0_0010_11, 7'b1_0001_00,
    7'b0_0001_00, 7'b0_0000_00, 7'b0_0001_00, 7'b0_0001_00, 7'b0_0001_11
  };

  initial begin
    #1_000_000;
    n_mis++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 shut_a", {31'd0, shut_a}, 0);
    check("R1 shut_b", {31'd0, shut_b}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), rv);
      check("R1 reg", rv, 0);
    end

    wreg(2'd0, 32'h0000_0003);
    wreg(2'd1, 32'h0201_0203);
    // R2 R4 R6 R7 table walk
    for (int k = 0; k < 15; k++) begin
      if (VEC[k][6]) restart();
      period(VEC[k][5:2], 1);
      check($sformatf("R2/R4/R6/R7 vec%0d shut_a", k), {31'd0, shut_a}, {31'd0, VEC[k][1]});
      check($sformatf("R2/R4/R6/R7 vec%0d shut_b", k), {31'd0, shut_b}, {31'd0, VEC[k][0]});
    end

    // R9 status accumulated, cleared by read; R10 no irq without enable
    rreg(2'd2, rv);
    check("R9 status set", rv, 32'hF);
    rreg(2'd2, rv);
    check("R9 status cleared", rv, 0);
    check("R10 irq off when disabled", {31'd0, irq}, 0);

    // R7 global enable releases the latch
    check("R7 latched before", {30'd0, shut_a, shut_b}, 3);
    glb_en = 1'b0;
    @(negedge clk);
    glb_en = 1'b1;
    @(negedge clk);
    check("R7 released by global", {30'd0, shut_a, shut_b}, 0);

    // R3 immediate trip, R9 set wins over read, R10 interrupt
    wreg(2'd0, 32'h0000_0043);
    wreg(2'd1, 32'h0200_0203);
    fault = 4'b0100;
    repeat (2) @(negedge clk);
    check("R3 not before 3 cycles", {31'd0, shut_a}, 0);
    addr = 2'd2; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check("R3 shut_a at 3 cycles", {31'd0, shut_a}, 1);
    check("R3 shut_b untouched", {31'd0, shut_b}, 0);
    check("R10 irq raised", {31'd0, irq}, 1);
    fault = '0;
    repeat (3) @(negedge clk);
    rreg(2'd2, rv);
    check("R9 set wins over read", rv, 32'h4);
    rreg(2'd3, rv);
    check("R10 int flag", rv, 32'h4);
    check("R10 irq cleared by read", {31'd0, irq}, 0);

    // R8 enable gating
    restart();
    wreg(2'd0, 32'h0000_0000);
    wreg(2'd1, 32'h0200_0200);
    period(4'b0100, 1);
    check("R8 A disabled", {30'd0, shut_a, shut_b}, 0);
    period(4'b0001, 1);
    check("R8 CL disabled", {30'd0, shut_a, shut_b}, 0);
    wreg(2'd0, 32'h0000_0001);
    period(4'b0100, 1);
    check("R8 group still disabled", {30'd0, shut_a, shut_b}, 0);
    period(4'b0001, 1);
    check("R8 R2 CL enabled masks both", {30'd0, shut_a, shut_b}, 3);

    // R5 several pulses in one period count once
    restart();
    wreg(2'd0, 32'h0000_0003);
    wreg(2'd1, 32'h021F_1F1F);
    period(4'b1000, 2);
    check("R5 two pulses one count", {30'd0, shut_a, shut_b}, 0);
    period(4'b1000, 1);
    check("R5 R2 second period trips B", {30'd0, shut_a, shut_b}, 1);

    // R4 limit 31
    restart();
    for (int p = 0; p < 30; p++) period(4'b0100, 1);
    check("R4 30 periods below 31", {30'd0, shut_a, shut_b}, 0);
    period(4'b0100, 1);
    check("R4 31st period trips A", {30'd0, shut_a, shut_b}, 2);

    // R11 readback
    rreg(2'd1, rv);
    check("R11 limit readback", rv, 32'h021F_1F1F);
    rreg(2'd0, rv);
    check("R11 ctrl readback", rv, 32'h0000_0003);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule